// File: doc/BRIEF.md
# Striped Framebuffer Page Writer

This block moves one 16-row stripe of a monochrome frame from a local byte buffer to a serial graphic display controller. The buffer holds the stripe as two halves of `COLS` bytes. Each byte is one column of eight vertical pixels. The first half is the upper eight rows and the second half is the lower eight rows. A start strobe carries a stripe index, and the block then writes the two display pages that the stripe covers, one after the other.

Each page is written the same way. The chip is first deselected and command mode is chosen. The chip is then selected and three commands follow: the column address is reset to zero as a high nibble and a low nibble, and then the page is selected. After that the data/command line switches to data and the half's bytes stream out in ascending address order. Every byte goes out most significant bit first over a clock/data pair. Buffer reads have one cycle of latency. The next byte is fetched while the current one is still shifting, so bytes within a page follow each other at a fixed rate. An index beyond the panel's stripe count is rejected with an error pulse, and nothing is sent.

Top module: `stripe_page_writer`

## Requirements
- R1: After reset, chip select (`lcd_csn_o`, active low) is high, `lcd_sck_o`, `lcd_dc_o`, `rd_en_o`, `done_o` and `err_o` are low.
- R2: Each page begins with chip select high for `CS_GAP` cycles. Chip select then goes low, and the block sends three command bytes with `lcd_dc_o` low: 0x10, 0x00, then the page command.
- R3: The page command is 0xB0 OR the page number. For stripe index s, the first page is 2*s and the second page is 2*s+1.
- R4: After the page command, `lcd_dc_o` is high and `COLS` data bytes follow. For the first page they are read from buffer addresses 0 to `COLS`-1 in ascending order, and for the second page from addresses `COLS` to 2*`COLS`-1.
- R5: Every bit is placed on `lcd_mosi_o` most significant bit first, with `lcd_sck_o` low for `CLK_DIV` cycles and then high for `CLK_DIV` cycles. `lcd_mosi_o` does not change while `lcd_sck_o` is high.
- R6: Chip select rises once between the two pages and once after the last byte, so there are two rises per stripe. `done_o` is a single-cycle pulse after the last byte, with chip select high.
- R7: A start with stripe index of `NUM_STRIPES` or more gives a one-cycle `err_o` pulse in the cycle after the strobe. There is no chip select, no buffer read and no `done_o`.
- R8: A start strobe during a transfer is ignored, and the running stripe completes unchanged with one `done_o`.
- R9: At most one buffer read is outstanding. `rd_data_i` is taken one cycle after `rd_en_o`. Within a page, consecutive data bytes start 16*`CLK_DIV`+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| stripe_i | input | IDX_W | Stripe index sampled with the strobe |
| rd_en_o | output | 1 | Buffer read enable |
| rd_addr_o | output | ADDR_W | Buffer read address |
| rd_data_i | input | 8 | Buffer read data, valid one cycle after enable |
| lcd_csn_o | output | 1 | Display chip select, active low |
| lcd_dc_o | output | 1 | Low for command bytes, high for data bytes |
| lcd_sck_o | output | 1 | Serial clock, data sampled on its rising edge |
| lcd_mosi_o | output | 1 | Serial data |
| done_o | output | 1 | Stripe finished pulse |
| err_o | output | 1 | Rejected stripe index pulse |

## Verification
The error pulse is due in the cycle right after the strobe edge. The bench drives the strobe on a falling edge and reads `err_o` at the next falling edge, then one falling edge later to confirm it has cleared. Serial results have no single due cycle, so a falling-edge monitor rebuilds each byte at the `lcd_sck_o` rising edges. For each byte it records the cycle of its first rising edge, together with the data/command level and chip select level. Data-byte spacing is then compared with the exact 16*`CLK_DIV`+1 figure, and high-phase lengths with `CLK_DIV`. `done_o` and the chip select rises are counted as pulses over the whole run, and the bench reads them once the done pulse has been seen.

// File: rtl/spw_pkg.sv
package spw_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DESEL,
      S_CMD,
      S_DRAIN,
      S_DATA,
      S_DONE
   } spw_state_e;

   localparam logic [7:0] CMD_COL_HI    = 8'h10;
   localparam logic [7:0] CMD_COL_LO    = 8'h00;
   localparam logic [7:0] CMD_PAGE_BASE = 8'hB0;

   function automatic logic [7:0] page_cmd(input logic [3:0] pg);
      return CMD_PAGE_BASE | {4'h0, pg};
   endfunction

endpackage

// File: rtl/spw_byte_shifter.sv
module spw_byte_shifter #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [7:0] byte_i,
   output logic       busy_o,
   output logic       sck_o,
   output logic       mosi_o
);

   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic [7:0] sh_q;
   logic [2:0] bit_q;
   logic       ph_q;
   logic       busy_q;
   logic       sck_q;
   logic       tick;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("spw_byte_shifter: CLK_DIV must be at least 1");
      end
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (load_i || !busy_q || div_q == DIV_W'(CLK_DIV - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = (div_q == DIV_W'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bit_q  <= '0;
         ph_q   <= 1'b0;
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
      end else if (load_i) begin
         sh_q   <= byte_i;
         bit_q  <= '0;
         ph_q   <= 1'b0;
         busy_q <= 1'b1;
         sck_q  <= 1'b0;
      end else if (busy_q && tick) begin
         if (!ph_q) begin
            ph_q  <= 1'b1;
            sck_q <= 1'b1;
         end else begin
            ph_q  <= 1'b0;
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
               busy_q <= 1'b0;
            end else begin
               bit_q <= bit_q + 1'b1;
               sh_q  <= {sh_q[6:0], 1'b0};
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign sck_o  = sck_q;
   assign mosi_o = sh_q[7];

   // R5: data line holds while the serial clock is high
   a_r5_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_q && $past(sck_q)) |-> $stable(sh_q[7]));

   // R9: a new byte is only accepted when the previous one is finished
   a_r9_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !busy_q);

endmodule

// File: rtl/spw_seq.sv
module spw_seq
   import spw_pkg::*;
#(
   parameter int COLS        = 128,
   parameter int NUM_STRIPES = 4,
   parameter int IDX_W       = 3,
   parameter int CS_GAP      = 2,
   localparam int COL_W      = $clog2(COLS),
   localparam int ADDR_W     = COL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  stripe_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   input  logic              sh_busy_i,
   output logic              sh_load_o,
   output logic [7:0]        sh_byte_o,
   output logic              csn_o,
   output logic              dc_o,
   output logic              done_o,
   output logic              err_o
);

   localparam int SW    = (NUM_STRIPES > 1) ? $clog2(NUM_STRIPES) : 1;
   localparam int CNT_W = COL_W + 1;
   localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

   spw_state_e        state_q;
   logic [SW-1:0]     stripe_q;
   logic              half_q;
   logic [1:0]        cmd_idx_q;
   logic [GAP_W-1:0]  gap_q;
   logic [CNT_W-1:0]  rd_cnt_q;
   logic [CNT_W-1:0]  sent_q;
   logic              pend_q;
   logic              nxt_vld_q;
   logic [7:0]        nxt_q;
   logic              err_q;
   logic              idx_ok;
   logic [3:0]        page;
   logic [7:0]        cmd_byte;

   assign idx_ok = (int'(stripe_i) < NUM_STRIPES);
   assign page   = 4'({stripe_q, half_q});

   always_comb begin
      case (cmd_idx_q)
         2'd0:    cmd_byte = CMD_COL_HI;
         2'd1:    cmd_byte = CMD_COL_LO;
         default: cmd_byte = page_cmd(page);
      endcase
   end

   assign rd_en_o   = (state_q == S_DATA) && !nxt_vld_q && !pend_q &&
                      (rd_cnt_q < CNT_W'(COLS));
   assign rd_addr_o = {half_q, rd_cnt_q[COL_W-1:0]};
   assign sh_load_o = !sh_busy_i &&
                      ((state_q == S_CMD) || (state_q == S_DATA && nxt_vld_q));
   assign sh_byte_o = (state_q == S_DATA) ? nxt_q : cmd_byte;
   assign csn_o     = (state_q == S_IDLE) || (state_q == S_DESEL) || (state_q == S_DONE);
   assign dc_o      = (state_q == S_DATA);
   assign done_o    = (state_q == S_DONE);
   assign err_o     = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         stripe_q  <= '0;
         half_q    <= 1'b0;
         cmd_idx_q <= '0;
         gap_q     <= '0;
         rd_cnt_q  <= '0;
         sent_q    <= '0;
         pend_q    <= 1'b0;
         nxt_vld_q <= 1'b0;
         nxt_q     <= '0;
         err_q     <= 1'b0;
      end else begin
         err_q <= start_i && (state_q == S_IDLE) && !idx_ok;
         case (state_q)
            S_IDLE: begin
               if (start_i && idx_ok) begin
                  stripe_q <= SW'(stripe_i);
                  half_q   <= 1'b0;
                  gap_q    <= '0;
                  state_q  <= S_DESEL;
               end
            end
            S_DESEL: begin
               if (gap_q == GAP_W'(CS_GAP - 1)) begin
                  cmd_idx_q <= '0;
                  state_q   <= S_CMD;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            S_CMD: begin
               if (sh_load_o) begin
                  if (cmd_idx_q == 2'd2) state_q <= S_DRAIN;
                  else cmd_idx_q <= cmd_idx_q + 1'b1;
               end
            end
            S_DRAIN: begin
               if (!sh_busy_i) begin
                  rd_cnt_q  <= '0;
                  sent_q    <= '0;
                  pend_q    <= 1'b0;
                  nxt_vld_q <= 1'b0;
                  state_q   <= S_DATA;
               end
            end
            S_DATA: begin
               pend_q <= rd_en_o;
               if (rd_en_o) rd_cnt_q <= rd_cnt_q + 1'b1;
               if (pend_q) begin
                  nxt_q     <= rd_data_i;
                  nxt_vld_q <= 1'b1;
               end else if (sh_load_o) begin
                  nxt_vld_q <= 1'b0;
               end
               if (sh_load_o) sent_q <= sent_q + 1'b1;
               if (sent_q == CNT_W'(COLS) && !sh_busy_i) begin
                  if (!half_q) begin
                     half_q  <= 1'b1;
                     gap_q   <= '0;
                     state_q <= S_DESEL;
                  end else begin
                     state_q <= S_DONE;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R9: never two reads in consecutive cycles, so at most one in flight
   a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |=> !rd_en_o);

   // R7: a rejected index leaves the sequencer idle
   a_r7_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (state_q == S_IDLE));

   // R6: the done pulse arrives only once the serial line is quiet
   a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !sh_busy_i);

   // R2: bytes are only launched with the chip selected
   a_r2_sel_before_load: assert property (@(posedge clk) disable iff (!rst_n)
      sh_load_o |-> !csn_o);

endmodule

// File: rtl/stripe_page_writer.sv
module stripe_page_writer #(
   parameter int COLS        = 128,
   parameter int NUM_STRIPES = 4,
   parameter int IDX_W       = 3,
   parameter int CLK_DIV     = 2,
   parameter int CS_GAP      = 2,
   localparam int ADDR_W     = $clog2(COLS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  stripe_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic              lcd_csn_o,
   output logic              lcd_dc_o,
   output logic              lcd_sck_o,
   output logic              lcd_mosi_o,
   output logic              done_o,
   output logic              err_o
);

   generate
      if (COLS < 2 || (COLS & (COLS - 1)) != 0 || COLS > 256) begin : g_bad_cols
         $error("stripe_page_writer: COLS must be a power of two from 2 to 256");
      end
      if (NUM_STRIPES < 1 || 2 * NUM_STRIPES > 16) begin : g_bad_stripes
         $error("stripe_page_writer: page number must fit the low nibble");
      end
      if ((1 << IDX_W) < NUM_STRIPES) begin : g_bad_idx
         $error("stripe_page_writer: IDX_W too narrow for NUM_STRIPES");
      end
      if (CS_GAP < 1) begin : g_bad_gap
         $error("stripe_page_writer: CS_GAP must be at least 1");
      end
   endgenerate

   logic       sh_busy;
   logic       sh_load;
   logic [7:0] sh_byte;

   spw_seq #(
      .COLS        (COLS),
      .NUM_STRIPES (NUM_STRIPES),
      .IDX_W       (IDX_W),
      .CS_GAP      (CS_GAP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .stripe_i  (stripe_i),
      .rd_en_o   (rd_en_o),
      .rd_addr_o (rd_addr_o),
      .rd_data_i (rd_data_i),
      .sh_busy_i (sh_busy),
      .sh_load_o (sh_load),
      .sh_byte_o (sh_byte),
      .csn_o     (lcd_csn_o),
      .dc_o      (lcd_dc_o),
      .done_o    (done_o),
      .err_o     (err_o)
   );

   spw_byte_shifter #(
      .CLK_DIV (CLK_DIV)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (sh_load),
      .byte_i (sh_byte),
      .busy_o (sh_busy),
      .sck_o  (lcd_sck_o),
      .mosi_o (lcd_mosi_o)
   );

   // R4: mode and select lines do not move while a byte is shifting
   a_r4_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_busy && $past(sh_busy)) |-> ($stable(lcd_dc_o) && $stable(lcd_csn_o)));

endmodule

// File: tb/tb_stripe_page_writer.sv
module tb_stripe_page_writer;

   localparam int COLS    = 128;
   localparam int CLK_DIV = 2;
   localparam int NBYTES  = 2 * (3 + COLS);
   localparam int NVEC    = 6;
   // {stripe[3:0], seed[7:0], expect_err[3:0]}
   localparam logic [15:0] VEC [NVEC] = '{
      {4'd0, 8'd3,  4'd0},
      {4'd3, 8'd11, 4'd0},
      {4'd4, 8'd5,  4'd1},
      {4'd1, 8'd29, 4'd0},
      {4'd7, 8'd9,  4'd1},
      {4'd2, 8'd77, 4'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] stripe = '0;
   logic       rd_en;
   logic [7:0] rd_addr;
   logic [7:0] rd_data = '0;
   logic       csn, dc, sck, mosi, done, err;

   logic [7:0] mem [256];

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   stripe_page_writer #(
      .COLS(COLS), .NUM_STRIPES(4), .IDX_W(3), .CLK_DIV(CLK_DIV), .CS_GAP(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stripe_i(stripe),
      .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .lcd_csn_o(csn), .lcd_dc_o(dc), .lcd_sck_o(sck), .lcd_mosi_o(mosi),
      .done_o(done), .err_o(err)
   );

   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   // capture monitor, sampled on falling edges
   logic clr = 1'b1;
   int   cyc = 0;
   int   ncap, nbit, t_first, csn_rises, done_cnt, err_cnt, rd_cnt;
   int   hi_run, hi_min, hi_max, mosi_bad, csn_bad, csn_low_seen;
   logic [7:0] shreg;
   logic prev_sck, prev_csn, prev_mosi;
   logic [7:0] cap_byte [NBYTES + 8];
   logic       cap_dc   [NBYTES + 8];
   int         cap_t    [NBYTES + 8];

   always @(negedge clk) begin
      cyc++;
      if (clr) begin
         ncap = 0; nbit = 0; csn_rises = 0; done_cnt = 0; err_cnt = 0;
         rd_cnt = 0; hi_run = 0; hi_min = 1000; hi_max = 0; mosi_bad = 0;
         csn_bad = 0; csn_low_seen = 0; shreg = '0;
      end else begin
         if (csn && !prev_csn) csn_rises++;
         if (!csn) csn_low_seen = 1;
         if (done) done_cnt++;
         if (err) err_cnt++;
         if (rd_en) rd_cnt++;
         if (sck) begin
            if (prev_sck && mosi !== prev_mosi) mosi_bad++;
            hi_run++;
            if (!prev_sck) begin
               shreg = {shreg[6:0], mosi};
               if (csn) csn_bad++;
               nbit++;
               if (nbit == 1) t_first = cyc;
               if (nbit == 8) begin
                  if (ncap < NBYTES + 8) begin
                     cap_byte[ncap] = shreg;
                     cap_dc[ncap]   = dc;
                     cap_t[ncap]    = t_first;
                  end
                  ncap++;
                  nbit = 0;
               end
            end
         end else if (prev_sck) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
         end
      end
      prev_sck = sck; prev_csn = csn; prev_mosi = mosi;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a, input int seed);
      return 8'(a * seed + (a >> 3) + seed * 7);
   endfunction

   task automatic fill(input int seed);
      for (int a = 0; a < 256; a++) mem[a] = pat(a, seed);
   endtask

   task automatic clear_mon();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic pulse_start(input logic [2:0] s);
      @(negedge clk); start = 1'b1; stripe = s;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (done_cnt == 0 && n < 20000) begin @(negedge clk); n++; end
      repeat (4) @(negedge clk);
   endtask

   task automatic check_stripe(input int s, input string tag);
      int mis_cmd = 0, mis_dc = 0, mis_dat = 0, first_bad = -1;
      chk(ncap == NBYTES, {tag, " R4 byte count"}, ncap, NBYTES);
      if (ncap == NBYTES) begin
         for (int h = 0; h < 2; h++) begin
            int b = h * (3 + COLS);
            if (cap_byte[b] != 8'h10 || cap_byte[b+1] != 8'h00) mis_cmd++;
            if (cap_dc[b] || cap_dc[b+1] || cap_dc[b+2]) mis_dc++;
            chk(cap_byte[b+2] == (8'hB0 | 8'(2*s+h)), {tag, " R3 page command"},
                cap_byte[b+2], 8'hB0 | (2*s+h));
            for (int i = 0; i < COLS; i++) begin
               if (!cap_dc[b+3+i]) mis_dc++;
               if (cap_byte[b+3+i] != mem[h*COLS+i]) begin
                  mis_dat++;
                  if (first_bad < 0) first_bad = h*COLS+i;
               end
            end
            chk(cap_t[b+4] - cap_t[b+3] == 16*CLK_DIV+1, {tag, " R9 byte spacing"},
                cap_t[b+4] - cap_t[b+3], 16*CLK_DIV+1);
         end
      end
      chk(mis_cmd == 0, {tag, " R2 column reset commands"}, mis_cmd, 0);
      chk(mis_dc == 0, {tag, " R2 R4 data/command level"}, mis_dc, 0);
      chk(mis_dat == 0, {tag, " R4 data order"}, first_bad, -1);
      chk(csn_rises == 2, {tag, " R6 chip select rises"}, csn_rises, 2);
      chk(done_cnt == 1, {tag, " R6 done pulse"}, done_cnt, 1);
      chk(csn == 1'b1, {tag, " R6 deselected at end"}, csn, 1);
      chk(csn_bad == 0, {tag, " R2 selected while clocking"}, csn_bad, 0);
      chk(hi_min == CLK_DIV && hi_max == CLK_DIV, {tag, " R5 clock high time"},
          hi_max, CLK_DIV);
      chk(mosi_bad == 0, {tag, " R5 data held while clock high"}, mosi_bad, 0);
      chk(rd_cnt == 2*COLS, {tag, " R9 read count"}, rd_cnt, 2*COLS);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(csn == 1 && sck == 0 && dc == 0, "R1 serial lines at reset",
          {csn, sck, dc}, 3'b100);
      chk(!rd_en && !done && !err, "R1 strobes at reset", {rd_en, done, err}, 0);
      rst_n = 1'b1;
      clr = 1'b0;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         int s    = int'(VEC[v][15:12]);
         int seed = int'(VEC[v][11:4]);
         bit eerr = VEC[v][0];
         fill(seed);
         clear_mon();
         if (eerr) begin
            // R7: rejected index, error one cycle after the strobe
            @(negedge clk); start = 1'b1; stripe = 3'(s);
            @(negedge clk); start = 1'b0;
            chk(err == 1'b1, "R7 error pulse due", err, 1);
            @(negedge clk);
            chk(err == 1'b0, "R7 error pulse width", err, 0);
            repeat (200) @(negedge clk);
            chk(csn_low_seen == 0 && rd_cnt == 0 && done_cnt == 0 && ncap == 0,
                "R7 no transfer", csn_low_seen + rd_cnt + done_cnt + ncap, 0);
         end else begin
            pulse_start(3'(s));
            wait_done();
            check_stripe(s, $sformatf("vec%0d", v));
         end
      end

      // R8: strobe during a transfer is ignored
      fill(41);
      clear_mon();
      pulse_start(3'd1);
      repeat (500) @(negedge clk);
      pulse_start(3'd2);
      wait_done();
      check_stripe(1, "R8 restart ignored");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule